// File: doc/BRIEF.md
# Parallel Group Register Conflict Checker

This block examines the register footprint of one group of instructions that are meant to issue together. Each of up to eight instruction slots presents a slot valid bit, three source register numbers with their own valid bits and one destination register number with its valid bit, all naming entries of a 32-entry register file. The block decides whether the group is portable, meaning that no register use in one instruction collides with a register use in another. Which instructions belong to the group is decided upstream. The block does not execute anything.

Two strictness levels are available through a mode pin. In per-register mode, any number of instructions may read the same register. A register that is written by one instruction must not be read or written by any other instruction. In per-group mode, the register file is split into eight groups of four consecutive registers. An instruction that touches any register of a group, by reading or by writing, owns that whole group for the cycle. That instruction may still use several registers inside its own groups.

The input side is a valid-only stream: `start_i` is the valid strobe. The block accepts a group on every cycle with no back-pressure, so there is no ready pin, and a new group may be presented on back-to-back cycles. On the output side, `done_o` marks a one-cycle valid beat. It appears one cycle after the start strobe and has no ready. The verdict and the offending pair stay unchanged until the next start, so a consumer may read them late.

Top module: `pgc_top`

## Requirements
- R1: While reset is asserted and after it is released, `done_o` is 0, `ok_o` is 1, and `bad_a_o` and `bad_b_o` are 0.
- R2: A group sampled on a rising edge with `start_i` high produces `done_o` high for exactly the following cycle, and the new verdict is visible in that same cycle.
- R3: With `strict_i` = 0, several valid instructions that read the same register and write no register of another pair give `ok_o` = 1.
- R4: In both modes, a register written by one valid instruction and read or written by another valid instruction gives `ok_o` = 0.
- R5: With `strict_i` = 1, register r belongs to group r/4. Two valid instructions that touch any register of the same group, even by reading only, give `ok_o` = 0. Registers in different groups do not conflict.
- R6: A single instruction may read and write several registers of one group, including the same register, without a conflict in either mode.
- R7: A slot whose `ins_valid_i` bit is 0 is ignored, and so is any source or destination field whose own valid bit is 0. Slot k uses `ins_valid_i[k]`, `dst_valid_i[k]`, `dst_reg_i[5k+4:5k]`, `src_valid_i[3k+s]` and `src_reg_i[5(3k+s)+4 : 5(3k+s)]` for source s = 0..2.
- R8: When conflicts exist, `bad_a_o` and `bad_b_o` hold the pair (a, b) with a < b that is first in lexicographic order: lowest a, then lowest b. When no conflict exists, both are 0.
- R9: Inputs are sampled only on cycles with `start_i` high. At other times the outputs `ok_o`, `bad_a_o` and `bad_b_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Valid strobe: sample the group this cycle |
| strict_i | input | 1 | 0 = per-register rule, 1 = per-group rule |
| ins_valid_i | input | 8 | Slot valid bits |
| src_valid_i | input | 24 | Source field valid bits, three per slot |
| src_reg_i | input | 120 | Source register numbers, 5 bits each |
| dst_valid_i | input | 8 | Destination field valid bits |
| dst_reg_i | input | 40 | Destination register numbers, 5 bits each |
| done_o | output | 1 | One-cycle result beat |
| ok_o | output | 1 | 1 = group portable |
| bad_a_o | output | 3 | Lower slot index of the first conflicting pair |
| bad_b_o | output | 3 | Higher slot index of the first conflicting pair |

## Verification
The assertions assume that `start_i` is low during reset, so the first result beat can only follow a strobe seen after release. They also assume that inputs are stable around the sampling edge. The assertion on shared reads holds only when no valid destination was present in the sampled group. The bench drives every input on the falling edge and keeps `start_i` low throughout reset. Its random groups draw register numbers from a narrow range, so that conflicts of each kind occur often in both modes.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int SLOTS_DEF = 8;
  localparam int REGS_DEF  = 32;
  localparam int SRCS_DEF  = 3;
  localparam int GROUP_DEF = 4;

  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_GRP = 1'b1
  } mode_e;
endpackage

// File: rtl/pgc_footprint.sv
module pgc_footprint #(
  parameter int REGS  = pgc_pkg::REGS_DEF,
  parameter int SRCS  = pgc_pkg::SRCS_DEF,
  parameter int GROUP = pgc_pkg::GROUP_DEF,
  localparam int RW   = $clog2(REGS),
  localparam int NG   = REGS / GROUP
) (
  input  logic             valid_i,
  input  logic [SRCS-1:0]  src_v_i,
  input  logic [SRCS*RW-1:0] src_r_i,
  input  logic             dst_v_i,
  input  logic [RW-1:0]    dst_r_i,
  output logic [REGS-1:0]  rd_o,
  output logic [REGS-1:0]  wr_o,
  output logic [NG-1:0]    grp_o
);
  // Read set: one-hot OR of every enabled source field.
  always_comb begin
    rd_o = '0;
    for (int s = 0; s < SRCS; s++) begin
      if (valid_i && src_v_i[s]) begin
        rd_o[src_r_i[s*RW +: RW]] = 1'b1;
      end
    end
  end

  // Write set: at most one register.
  always_comb begin
    wr_o = '0;
    if (valid_i && dst_v_i) begin
      wr_o[dst_r_i] = 1'b1;
    end
  end

  // Group touch set: any access to a member marks the group.
  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_o[g] = |(rd_o[g*GROUP +: GROUP] | wr_o[g*GROUP +: GROUP]);
  end
endmodule

// File: rtl/pgc_pair_matrix.sv
module pgc_pair_matrix #(
  parameter int SLOTS = pgc_pkg::SLOTS_DEF,
  parameter int REGS  = pgc_pkg::REGS_DEF,
  parameter int NG    = pgc_pkg::REGS_DEF / pgc_pkg::GROUP_DEF
) (
  input  logic                   grp_mode_i,
  input  logic [SLOTS*REGS-1:0]  rd_i,
  input  logic [SLOTS*REGS-1:0]  wr_i,
  input  logic [SLOTS*NG-1:0]    grp_i,
  output logic [SLOTS*SLOTS-1:0] conf_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_row
    for (genvar j = 0; j < SLOTS; j++) begin : g_col
      if (j > i) begin : g_upper
        logic [REGS-1:0] rd_a, wr_a, rd_b, wr_b;
        logic            hit_reg, hit_grp;
        assign rd_a = rd_i[i*REGS +: REGS];
        assign wr_a = wr_i[i*REGS +: REGS];
        assign rd_b = rd_i[j*REGS +: REGS];
        assign wr_b = wr_i[j*REGS +: REGS];
        assign hit_reg = |((wr_a & (rd_b | wr_b)) | (wr_b & rd_a));
        assign hit_grp = |(grp_i[i*NG +: NG] & grp_i[j*NG +: NG]);
        assign conf_o[i*SLOTS+j] = grp_mode_i ? hit_grp : hit_reg;
      end else begin : g_lower
        assign conf_o[i*SLOTS+j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pgc_first_pair.sv
module pgc_first_pair #(
  parameter int SLOTS = pgc_pkg::SLOTS_DEF,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic [SLOTS*SLOTS-1:0] conf_i,
  output logic                   any_o,
  output logic [IW-1:0]          a_o,
  output logic [IW-1:0]          b_o
);
  // Scan from the highest pair down; the last hit kept is the
  // lexicographically smallest (lowest a, then lowest b).
  always_comb begin
    any_o = 1'b0;
    a_o   = '0;
    b_o   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      for (int j = SLOTS - 1; j >= 0; j--) begin
        if (j > i && conf_i[i*SLOTS+j]) begin
          any_o = 1'b1;
          a_o   = IW'(i);
          b_o   = IW'(j);
        end
      end
    end
  end
endmodule

// File: rtl/pgc_top.sv
module pgc_top #(
  parameter int SLOTS = pgc_pkg::SLOTS_DEF,
  parameter int REGS  = pgc_pkg::REGS_DEF,
  parameter int SRCS  = pgc_pkg::SRCS_DEF,
  parameter int GROUP = pgc_pkg::GROUP_DEF,
  localparam int RW   = $clog2(REGS),
  localparam int IW   = $clog2(SLOTS),
  localparam int NG   = REGS / GROUP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    strict_i,
  input  logic [SLOTS-1:0]        ins_valid_i,
  input  logic [SLOTS*SRCS-1:0]   src_valid_i,
  input  logic [SLOTS*SRCS*RW-1:0] src_reg_i,
  input  logic [SLOTS-1:0]        dst_valid_i,
  input  logic [SLOTS*RW-1:0]     dst_reg_i,
  output logic                    done_o,
  output logic                    ok_o,
  output logic [IW-1:0]           bad_a_o,
  output logic [IW-1:0]           bad_b_o
);
  import pgc_pkg::*;

  logic [SLOTS*REGS-1:0]  rd_all, wr_all;
  logic [SLOTS*NG-1:0]    grp_all;
  logic [SLOTS*SLOTS-1:0] conf;
  logic                   any_conf;
  logic [IW-1:0]          first_a, first_b;
  mode_e                  mode;

  assign mode = mode_e'(strict_i);

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    pgc_footprint #(.REGS(REGS), .SRCS(SRCS), .GROUP(GROUP)) u_fp (
      .valid_i (ins_valid_i[k]),
      .src_v_i (src_valid_i[k*SRCS +: SRCS]),
      .src_r_i (src_reg_i[k*SRCS*RW +: SRCS*RW]),
      .dst_v_i (dst_valid_i[k]),
      .dst_r_i (dst_reg_i[k*RW +: RW]),
      .rd_o    (rd_all[k*REGS +: REGS]),
      .wr_o    (wr_all[k*REGS +: REGS]),
      .grp_o   (grp_all[k*NG +: NG])
    );
  end

  pgc_pair_matrix #(.SLOTS(SLOTS), .REGS(REGS), .NG(NG)) u_mat (
    .grp_mode_i (mode == MODE_GRP),
    .rd_i       (rd_all),
    .wr_i       (wr_all),
    .grp_i      (grp_all),
    .conf_o     (conf)
  );

  pgc_first_pair #(.SLOTS(SLOTS)) u_pick (
    .conf_i (conf),
    .any_o  (any_conf),
    .a_o    (first_a),
    .b_o    (first_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      ok_o    <= 1'b1;
      bad_a_o <= '0;
      bad_b_o <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        ok_o    <= ~any_conf;
        bad_a_o <= first_a;
        bad_b_o <= first_b;
      end
    end
  end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
  parameter int SLOTS = pgc_pkg::SLOTS_DEF,
  localparam int IW   = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             strict_i,
  input logic [SLOTS-1:0] ins_valid_i,
  input logic [SLOTS-1:0] dst_valid_i,
  input logic             done_o,
  input logic             ok_o,
  input logic [IW-1:0]    bad_a_o,
  input logic [IW-1:0]    bad_b_o
);
  assert_done_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $past(start_i));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start_i) |-> $stable({ok_o, bad_a_o, bad_b_o}));

  assert_pair_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> (bad_a_o < bad_b_o));

  assert_clean_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (bad_a_o == '0 && bad_b_o == '0));

  assert_pair_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |->
      ((($past(ins_valid_i) >> bad_a_o) & SLOTS'(1)) != '0 &&
       (($past(ins_valid_i) >> bad_b_o) & SLOTS'(1)) != '0));

  assert_shared_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(strict_i) && (($past(ins_valid_i) & $past(dst_valid_i)) == '0))
      |-> ok_o);
endmodule

bind pgc_top pgc_checker #(.SLOTS(SLOTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .strict_i    (strict_i),
  .ins_valid_i (ins_valid_i),
  .dst_valid_i (dst_valid_i),
  .done_o      (done_o),
  .ok_o        (ok_o),
  .bad_a_o     (bad_a_o),
  .bad_b_o     (bad_b_o)
);

// File: tb/tb_pgc_top.sv
module tb_pgc_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, strict_i = 1'b0;
  logic [7:0]   ins_valid_i = '0, dst_valid_i = '0;
  logic [23:0]  src_valid_i = '0;
  logic [119:0] src_reg_i = '0;
  logic [39:0]  dst_reg_i = '0;
  logic done_o, ok_o;
  logic [2:0] bad_a_o, bad_b_o;

  int checks = 0, failures = 0;

  // Bench-side group description
  logic       iv [N];
  logic       sv [N][3];
  logic [4:0] sr [N][3];
  logic       dv [N];
  logic [4:0] dr [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgc_top dut (.*);

  typedef struct packed {
    logic       strict;
    logic [2:0] ia; logic [4:0] ra; logic wa;
    logic [2:0] ib; logic [4:0] rb; logic wb;
    logic       exp_ok;
  } vec_t;

  // Two active slots per vector; each uses one register, as dest if w=1 else source 0.
  localparam vec_t VECS [10] = '{
    '{1'b0, 3'd0, 5'd5,  1'b0, 3'd1, 5'd5,  1'b0, 1'b1},  // R3 shared read
    '{1'b0, 3'd0, 5'd5,  1'b1, 3'd1, 5'd5,  1'b0, 1'b0},  // R4 write/read
    '{1'b0, 3'd2, 5'd7,  1'b0, 3'd6, 5'd7,  1'b1, 1'b0},  // R4 read/write
    '{1'b0, 3'd3, 5'd9,  1'b1, 3'd5, 5'd9,  1'b1, 1'b0},  // R4 write/write
    '{1'b0, 3'd0, 5'd4,  1'b1, 3'd1, 5'd5,  1'b0, 1'b1},  // R5 same group, loose mode
    '{1'b1, 3'd0, 5'd4,  1'b1, 3'd1, 5'd5,  1'b0, 1'b0},  // R5 same group, strict
    '{1'b1, 3'd1, 5'd8,  1'b0, 3'd4, 5'd11, 1'b0, 1'b0},  // R5 reads only, group 2
    '{1'b1, 3'd0, 5'd3,  1'b0, 3'd7, 5'd4,  1'b0, 1'b1},  // R5 groups 0 and 1
    '{1'b1, 3'd0, 5'd5,  1'b0, 3'd1, 5'd5,  1'b0, 1'b0},  // R5 strict shared read
    '{1'b1, 3'd7, 5'd31, 1'b1, 3'd6, 5'd28, 1'b1, 1'b0}   // R8 order a<b
  };

  task automatic clear_group();
    for (int k = 0; k < N; k++) begin
      iv[k] = 1'b0; dv[k] = 1'b0; dr[k] = '0;
      for (int s = 0; s < 3; s++) begin sv[k][s] = 1'b0; sr[k][s] = '0; end
    end
  endtask

  task automatic pack_group();
    for (int k = 0; k < N; k++) begin
      ins_valid_i[k] = iv[k];
      dst_valid_i[k] = dv[k];
      dst_reg_i[k*5 +: 5] = dr[k];
      for (int s = 0; s < 3; s++) begin
        src_valid_i[k*3+s] = sv[k][s];
        src_reg_i[(k*3+s)*5 +: 5] = sr[k][s];
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: pairwise intersection of read/write/group sets.
  task automatic model(input logic strict, output logic ok, output logic [2:0] a, output logic [2:0] b);
    logic [31:0] rm [N];
    logic [31:0] wm [N];
    logic [7:0]  gm [N];
    ok = 1'b1; a = '0; b = '0;
    for (int k = 0; k < N; k++) begin
      rm[k] = '0; wm[k] = '0; gm[k] = '0;
      if (iv[k]) begin
        for (int s = 0; s < 3; s++)
          if (sv[k][s]) begin rm[k][sr[k][s]] = 1'b1; gm[k][sr[k][s] >> 2] = 1'b1; end
        if (dv[k]) begin wm[k][dr[k]] = 1'b1; gm[k][dr[k] >> 2] = 1'b1; end
      end
    end
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        logic hit;
        hit = strict ? ((gm[i] & gm[j]) != 0)
                     : (((wm[i] & (rm[j] | wm[j])) | (wm[j] & rm[i])) != 0);
        if (hit && ok) begin ok = 1'b0; a = 3'(i); b = 3'(j); end
      end
  endtask

  // Present the group with a strobe, then check the result beat.
  task automatic run(input string tag, input logic strict, input logic eok,
                     input logic [2:0] ea, input logic [2:0] eb);
    @(negedge clk);
    pack_group();
    strict_i = strict;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " done"}, 32'(done_o), 32'd1);
    check({tag, " ok"},   32'(ok_o), 32'(eok));
    check({tag, " pair"}, {26'd0, bad_a_o, bad_b_o}, {26'd0, ea, eb});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic mok; logic [2:0] ma, mb;
    clear_group();
    pack_group();
    #(CLK_PERIOD * 3);
    // R1 reset state during reset
    check("R1 done in reset", 32'(done_o), 32'd0);
    check("R1 ok in reset", 32'(ok_o), 32'd1);
    check("R1 pair in reset", {26'd0, bad_a_o, bad_b_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", 32'(done_o), 32'd0);
    check("R1 ok after release", 32'(ok_o), 32'd1);

    // Vector table
    foreach (VECS[v]) begin
      vec_t t;
      logic [2:0] lo, hi;
      t = VECS[v];
      clear_group();
      iv[t.ia] = 1'b1; iv[t.ib] = 1'b1;
      if (t.wa) begin dv[t.ia] = 1'b1; dr[t.ia] = t.ra; end
      else begin sv[t.ia][0] = 1'b1; sr[t.ia][0] = t.ra; end
      if (t.wb) begin dv[t.ib] = 1'b1; dr[t.ib] = t.rb; end
      else begin sv[t.ib][0] = 1'b1; sr[t.ib][0] = t.rb; end
      lo = (t.ia < t.ib) ? t.ia : t.ib;
      hi = (t.ia < t.ib) ? t.ib : t.ia;
      if (t.exp_ok) run($sformatf("R3/R4/R5 vec%0d", v), t.strict, 1'b1, 3'd0, 3'd0);
      else run($sformatf("R4/R5/R8 vec%0d", v), t.strict, 1'b0, lo, hi);
    end

    // R2: done is a single beat
    @(negedge clk);
    check("R2 done drops", 32'(done_o), 32'd0);

    // R6: one instruction uses several registers of its own group, reads and writes r7
    clear_group();
    iv[2] = 1'b1;
    sv[2][0] = 1'b1; sr[2][0] = 5'd4;
    sv[2][1] = 1'b1; sr[2][1] = 5'd5;
    sv[2][2] = 1'b1; sr[2][2] = 5'd7;
    dv[2] = 1'b1; dr[2] = 5'd7;
    iv[3] = 1'b1; sv[3][0] = 1'b1; sr[3][0] = 5'd8;
    run("R6 strict own group", 1'b1, 1'b1, 3'd0, 3'd0);
    run("R6 loose own group", 1'b0, 1'b1, 3'd0, 3'd0);

    // R7: invalid slot conflicting on r7 is ignored
    iv[5] = 1'b0; dv[5] = 1'b1; dr[5] = 5'd7;
    run("R7 invalid slot", 1'b0, 1'b1, 3'd0, 3'd0);
    // R7: invalid source field naming r7 in slot 4 is ignored
    iv[4] = 1'b1; sv[4][1] = 1'b0; sr[4][1] = 5'd7;
    run("R7 invalid source field", 1'b0, 1'b1, 3'd0, 3'd0);
    // R7: invalid dest field naming r8 in slot 4 is ignored
    dv[4] = 1'b0; dr[4] = 5'd8;
    run("R7 invalid dest field", 1'b0, 1'b1, 3'd0, 3'd0);

    // R8: multiple conflicts, expect lowest pair (1,3)
    clear_group();
    iv[1] = 1'b1; dv[1] = 1'b1; dr[1] = 5'd20;
    iv[3] = 1'b1; sv[3][2] = 1'b1; sr[3][2] = 5'd20;
    iv[6] = 1'b1; sv[6][0] = 1'b1; sr[6][0] = 5'd20;
    iv[2] = 1'b1; dv[2] = 1'b1; dr[2] = 5'd12;
    iv[5] = 1'b1; sv[5][1] = 1'b1; sr[5][1] = 5'd12;
    run("R8 lowest pair", 1'b0, 1'b0, 3'd1, 3'd3);

    // R9: inputs changed without a strobe leave outputs alone
    @(negedge clk);
    clear_group();
    pack_group();
    strict_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 ok held", 32'(ok_o), 32'd0);
    check("R9 pair held", {26'd0, bad_a_o, bad_b_o}, {26'd0, 3'd1, 3'd3});
    check("R9 no done", 32'(done_o), 32'd0);

    // Random groups in both modes against the reference model
    for (int r = 0; r < 400; r++) begin
      logic st;
      st = r[0];
      for (int k = 0; k < N; k++) begin
        iv[k] = ($urandom_range(0, 3) != 0);
        dv[k] = ($urandom_range(0, 2) == 0);
        dr[k] = 5'($urandom_range(0, 15));
        for (int s = 0; s < 3; s++) begin
          sv[k][s] = ($urandom_range(0, 2) == 0);
          sr[k][s] = 5'($urandom_range(0, 15));
        end
      end
      model(st, mok, ma, mb);
      run(st ? "R4/R5/R8 random strict" : "R3/R4/R8 random loose", st, mok, ma, mb);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule